// File: doc/BRIEF.md
# Configuration Image CRC Validator

This block checks the integrity of a configuration image that is streamed into it one 16-bit word at a time. It runs an 8-bit CRC over the image bytes, compares the result with the checksum held in the upper byte of the image's final word, and reports a pass or fail flag along with the image's revision byte. It needs only a word counter, the running CRC and a few result registers. The image is never stored.

Images come in two lengths: 64 words and 220 words. A mode input, sampled at `start`, selects short-only, long-only or automatic checking. In automatic mode the block first tests whether the stream is a valid short image. If that test fails, it keeps running the same CRC and tests again at the long length. A single pass over the data therefore covers both candidates, and the short length is always tried first.

The block sits between a memory reader and the logic that decodes the image. The reader pulses `start`, presents the words in address order and may stall at any point by lowering `in_valid`. It marks the last word it has with `in_last`.

Top module: `cfg_image_crc_check`

## Requirements
- R1: Each byte updates the CRC as crc = T[crc XOR byte]. T is the byte table of the polynomial x^8+x^7+x^6+x^4+x^2+1 in right-shifting (reflected) form, with reversed constant 0xAB, so T[0x01]=0xF7 and T[0x02]=0xB9. The CRC is preset to 0xFF at `start`.
- R2: For every word before the decision word, bits [7:0] are folded in first and bits [15:8] second.
- R3: At the decision word only bits [7:0] are folded in and the result is XORed with 0xFF. `crc_ok` is 1 exactly when this value equals bits [15:8] of that word.
- R4: `revision` takes bits [7:0] of the decision word and holds that value until the next `start`.
- R5: `len_mode` is sampled at `start`. The encodings are 2'b00 short only (decision at word 64), 2'b01 long only (decision at word 220), and 2'b10 or 2'b11 automatic.
- R6: In automatic mode, word 64 is the decision word only if the short check passes there. Otherwise the CRC keeps running and word 220 is the decision word.
- R7: `done` is high for exactly one cycle: the cycle after the decision word is accepted. `crc_ok` and `revision` do not change between that point and the next `start`.
- R8: `start` clears `crc_ok` and `revision` to 0 and restarts counting at word 0. A word presented in the same cycle as `start` is not consumed.
- R9: If `in_last` comes with a word that is not a decision word, `done` pulses with `crc_ok`=0 and `revision`=0.
- R10: Words that arrive after a decision and before the next `start` are ignored. They produce no `done` and leave the outputs unchanged.
- R11: Cycles with `in_valid` low do not advance the check, so a stalled stream gives the same result as an unstalled one.
- R12: After reset, `done`, `crc_ok` and `revision` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new check; samples `len_mode` |
| len_mode | input | 2 | 00 short, 01 long, 1x automatic |
| in_valid | input | 1 | `in_word` holds an image word this cycle |
| in_word | input | 16 | Image word |
| in_last | input | 1 | This is the final word the reader has |
| done | output | 1 | One-cycle pulse when a decision is made |
| crc_ok | output | 1 | The decided image passed its CRC |
| revision | output | 8 | Low byte of the decision word |

## Verification
The bench builds images whose checksum is computed by a table-driven model. It sends them in short-only, long-only and automatic modes. A good short image and a deliberately corrupted checksum show whether the comparison at the final word is correct. An image whose checksum was computed with the bytes of each word in swapped order shows whether the low-then-high feed order is respected. In automatic mode, one image passes at the short length and then keeps streaming, and another fails there and passes at the long length. Together these separate the fallback from an early stop, and they confirm that trailing words are ignored. Truncated streams, stalled streams and a word sent together with `start` exercise the end-of-stream, stall and restart rules.

// File: rtl/crcv_pkg.sv
package crcv_pkg;
    localparam int CRC_W = 8;

    typedef enum logic [1:0] {
        MODE_SHORT = 2'b00,
        MODE_LONG  = 2'b01,
        MODE_AUTO  = 2'b10
    } crcv_mode_e;
endpackage

// File: rtl/crcv_byte_step.sv
module crcv_byte_step #(
    parameter int         CRC_W     = 8,
    parameter logic [7:0] POLY_REFL = 8'hAB
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       data_in,
    output logic [CRC_W-1:0] crc_out
);
    logic [CRC_W-1:0] stg [0:8];

    assign stg[0] = crc_in ^ CRC_W'(data_in);

    for (genvar k = 0; k < 8; k++) begin : g_shift
        assign stg[k+1] = (stg[k] >> 1) ^ (stg[k][0] ? CRC_W'(POLY_REFL) : '0);
    end

    assign crc_out = stg[8];
endmodule

// File: rtl/crcv_len_track.sv
module crcv_len_track
    import crcv_pkg::*;
#(
    parameter int SHORT_WORDS = 64,
    parameter int LONG_WORDS  = 220,
    localparam int CNT_W      = $clog2(LONG_WORDS)
) (
    input  logic [CNT_W-1:0] cnt,
    input  crcv_mode_e       mode,
    output logic             short_pt,
    output logic             long_pt,
    output logic             short_forced
);
    assign short_pt     = (cnt == CNT_W'(SHORT_WORDS - 1)) && (mode != MODE_LONG);
    assign long_pt      = (cnt == CNT_W'(LONG_WORDS - 1)) && (mode != MODE_SHORT);
    assign short_forced = (mode == MODE_SHORT);
endmodule

// File: rtl/cfg_image_crc_check.sv
module cfg_image_crc_check
    import crcv_pkg::*;
#(
    parameter int         SHORT_WORDS = 64,
    parameter int         LONG_WORDS  = 220,
    parameter logic [7:0] POLY_REFL   = 8'hAB
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  len_mode,
    input  logic        in_valid,
    input  logic [15:0] in_word,
    input  logic        in_last,
    output logic        done,
    output logic        crc_ok,
    output logic [7:0]  revision
);
    localparam int CNT_W = $clog2(LONG_WORDS);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CRC_W-1:0] crc;
        crcv_mode_e       mode;
        logic             done;
        logic             ok;
        logic [7:0]       rev;
    } state_t;

    state_t q, d;

    logic [CRC_W-1:0] crc_lo, crc_hi, crc_fin;
    logic             match, short_pt, long_pt, short_forced;
    crcv_mode_e       mode_in;

    crcv_byte_step #(.CRC_W(CRC_W), .POLY_REFL(POLY_REFL)) u_step_lo (
        .crc_in (q.crc),
        .data_in(in_word[7:0]),
        .crc_out(crc_lo)
    );

    crcv_byte_step #(.CRC_W(CRC_W), .POLY_REFL(POLY_REFL)) u_step_hi (
        .crc_in (crc_lo),
        .data_in(in_word[15:8]),
        .crc_out(crc_hi)
    );

    crcv_len_track #(.SHORT_WORDS(SHORT_WORDS), .LONG_WORDS(LONG_WORDS)) u_len (
        .cnt         (q.cnt),
        .mode        (q.mode),
        .short_pt    (short_pt),
        .long_pt     (long_pt),
        .short_forced(short_forced)
    );

    assign crc_fin = crc_lo ^ {CRC_W{1'b1}};
    assign match   = (crc_fin == in_word[15:8]);
    assign mode_in = len_mode[1] ? MODE_AUTO : crcv_mode_e'(len_mode);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.crc  = {CRC_W{1'b1}};
            d.mode = mode_in;
            d.ok   = 1'b0;
            d.rev  = '0;
        end else if (q.busy && in_valid) begin
            if ((short_pt && (short_forced || match)) || long_pt) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.ok   = match;
                d.rev  = in_word[7:0];
            end else if (in_last) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.ok   = 1'b0;
                d.rev  = '0;
            end else begin
                d.crc = crc_hi;
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.crc  <= {CRC_W{1'b1}};
            q.mode <= MODE_AUTO;
        end else begin
            q <= d;
        end
    end

    assign done     = q.done;
    assign crc_ok   = q.ok;
    assign revision = q.rev;

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_hold_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(start)) |-> $stable(crc_ok));
    assert_hold_rev_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(start)) |-> $stable(revision));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && !start) |=> !done);
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CNT_W'(LONG_WORDS));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!crc_ok && revision == 8'h00 && !done));
    assert_trunc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && in_valid && in_last && !start && !short_pt && !long_pt)
        |=> (done && !crc_ok && revision == 8'h00));
endmodule

// File: tb/cfg_image_crc_check_bench.sv
module cfg_image_crc_check_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  len_mode = 2'b00;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        in_last = 1'b0;
    logic        done, crc_ok;
    logic [7:0]  revision;

    int n_checks = 0;
    int n_errors = 0;

    logic [15:0] img [0:219];
    logic [7:0]  tbl [0:255];

    always #2 clk = ~clk;

    cfg_image_crc_check u_cfg_image_crc_check (
        .clk(clk), .rst_n(rst_n), .start(start), .len_mode(len_mode),
        .in_valid(in_valid), .in_word(in_word), .in_last(in_last),
        .done(done), .crc_ok(crc_ok), .revision(revision)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic build_table();
        for (int i = 0; i < 256; i++) begin
            logic [7:0] c;
            c = 8'(i);
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 8'hAB) : (c >> 1);
            tbl[i] = c;
        end
    endtask

    function automatic logic [7:0] model_crc(input int n, input bit swap);
        logic [7:0] c;
        c = 8'hFF;
        for (int w = 0; w < n - 1; w++) begin
            if (swap) begin
                c = tbl[c ^ img[w][15:8]];
                c = tbl[c ^ img[w][7:0]];
            end else begin
                c = tbl[c ^ img[w][7:0]];
                c = tbl[c ^ img[w][15:8]];
            end
        end
        c = tbl[c ^ img[n-1][7:0]];
        return c ^ 8'hFF;
    endfunction

    task automatic fill(input int seed);
        int x;
        x = seed;
        for (int i = 0; i < 220; i++) begin
            x = x * 1103515245 + 12345;
            img[i] = x[23:8];
        end
    endtask

    task automatic seal(input int n, input logic [7:0] rev);
        img[n-1][7:0]  = rev;
        img[n-1][15:8] = model_crc(n, 1'b0);
    endtask

    task automatic do_start(input logic [1:0] mode);
        @(negedge clk);
        len_mode = mode;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic stream(input int n, input int last_at, input bit gaps,
                          output int done_at, output int ndone);
        int prev;
        prev = -1;
        done_at = -1;
        ndone = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (done) begin ndone++; done_at = prev; end
            in_valid = 1'b1;
            in_word  = img[i];
            in_last  = (i == last_at);
            prev = i;
            if (gaps) begin
                @(negedge clk);
                if (done) begin ndone++; done_at = prev; end
                in_valid = 1'b0;
                in_word  = 16'hDEAD;
                in_last  = 1'b0;
            end
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (done) begin ndone++; done_at = prev; end
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R12 done", done, 0);
        check("R12 crc_ok", crc_ok, 0);
        check("R12 revision", revision, 0);
        check("R1 T[1]", tbl[1], 8'hF7);
        check("R1 T[2]", tbl[2], 8'hB9);
    endtask

    task automatic t_short_good();
        int da, nd;
        fill(11); seal(64, 8'h03);
        do_start(2'b00);
        stream(64, 63, 0, da, nd);
        check("R1 R3 short pass", crc_ok, 1);
        check("R4 revision", revision, 8'h03);
        check("R7 done at word 64", da, 63);
        check("R7 single done", nd, 1);
        repeat (5) @(negedge clk);
        check("R7 crc_ok held", crc_ok, 1);
        check("R4 revision held", revision, 8'h03);
    endtask

    task automatic t_short_bad();
        int da, nd;
        fill(12); seal(64, 8'h02);
        img[63][15:8] = img[63][15:8] ^ 8'h10;
        do_start(2'b00);
        stream(64, 63, 0, da, nd);
        check("R3 corrupt fails", crc_ok, 0);
        check("R4 revision on fail", revision, 8'h02);
        check("R5 short-only decides at 64", da, 63);
    endtask

    task automatic t_order();
        int da, nd;
        logic [7:0] good;
        fill(13);
        img[63][7:0] = 8'h01;
        good = model_crc(64, 1'b0);
        img[63][15:8] = model_crc(64, 1'b1);
        do_start(2'b00);
        stream(64, 63, 0, da, nd);
        check("R2 swapped-order checksum", crc_ok, (good == img[63][15:8]));
    endtask

    task automatic t_long_good(input bit gaps);
        int da, nd;
        fill(14); seal(220, 8'h05);
        do_start(2'b01);
        stream(220, 219, gaps, da, nd);
        check(gaps ? "R11 stalled long pass" : "R5 long pass", crc_ok, 1);
        check("R5 long decides at 220", da, 219);
        check("R4 long revision", revision, 8'h05);
    endtask

    task automatic t_auto_fallback();
        int da, nd;
        fill(15);
        img[63][15:8] = model_crc(64, 1'b0) ^ 8'h5A;
        seal(220, 8'h04);
        do_start(2'b10);
        stream(220, 219, 0, da, nd);
        check("R6 fallback pass", crc_ok, 1);
        check("R6 fallback decides at 220", da, 219);
        check("R6 fallback single done", nd, 1);
    endtask

    task automatic t_auto_short();
        int da, nd;
        fill(16); seal(64, 8'h01);
        do_start(2'b11);
        stream(220, 219, 0, da, nd);
        check("R6 auto short pass", crc_ok, 1);
        check("R6 auto stops at 64", da, 63);
        check("R10 trailing words no done", nd, 1);
        check("R10 revision unchanged", revision, 8'h01);
    endtask

    task automatic t_trunc();
        int da, nd;
        fill(17); seal(220, 8'h05);
        do_start(2'b01);
        stream(31, 30, 0, da, nd);
        check("R9 truncated done", da, 30);
        check("R9 truncated crc_ok", crc_ok, 0);
        check("R9 truncated revision", revision, 0);
    endtask

    task automatic t_start_prio();
        int da, nd;
        fill(18); seal(64, 8'h02);
        do_start(2'b00);
        stream(64, 63, 0, da, nd);
        @(negedge clk);
        len_mode = 2'b00;
        start = 1'b1; in_valid = 1'b1; in_word = img[5]; in_last = 1'b0;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        check("R8 start clears crc_ok", crc_ok, 0);
        check("R8 start clears revision", revision, 0);
        stream(64, 63, 0, da, nd);
        check("R8 word with start not consumed", crc_ok, 1);
        check("R8 decision position", da, 63);
    endtask

    initial begin
        build_table();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_short_good();
        t_short_bad();
        t_order();
        t_long_good(0);
        t_long_good(1);
        t_auto_fallback();
        t_auto_short();
        t_trunc();
        t_start_prio();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule